// File: doc/BRIEF.md
# Pseudorandom RAM Test Engine

This block tests a window of external byte-wide RAM for wiring faults. A one-cycle `start` pulse captures a base address, a byte count and an 8-bit seed. In the first pass the engine writes a pseudorandom byte stream to the window, one byte per clock. It then rewinds its pattern generator to the same seed and reads the window back in the same address order. Each byte that comes back is XORed with the byte the generator produces again for that address, and the differences are ORed into an 8-bit result.

A result of zero means every byte matched. Any set bit names a data line that disagreed at least once during the run. Two shorted data lines therefore show up as exactly those two bit positions. A stuck line shows up as its own bit.

The RAM port is synchronous. The write takes effect on the clock edge. Read data is returned one clock after the read request. Addresses wrap around the top of the address space. A parameter parser or a front end that prints the result sits outside this block.

Top module: `ramtest_engine`

## Requirements
- R1: Out of reset, `busy`, `done`, `mem_we` and `mem_re` are low and `result` is 0.
- R2: The clock edge that samples `start` is edge 0. While the block is idle, write cycle i (i = 0..N-1, N = `byte_count`) is the i-th cycle after edge 0. In that cycle `mem_we` is high, `mem_addr` = (`start_addr` + i) mod 2^ADDR_W and `mem_wdata` = p_i. Here p_0 is `seed`, or 0x01 when `seed` is 0, and p_(i+1) = {p_i[6:0], p_i[7]^p_i[5]^p_i[4]^p_i[3]}.
- R3: Directly after the write cycles come N read cycles. In each, `mem_re` is high and `mem_we` is low, and the addresses follow the same sequence as in R2. The RAM returns read data on `mem_rdata` one cycle after each read request.
- R4: `result` is the bitwise OR, over all N bytes, of (read byte XOR p_i). On a healthy RAM it is 0.
- R5: A fault confined to certain data lines sets only those bit positions of `result`. Two lines shorted as a wired-AND (bits 1 and 2) give a result within 0x06 that is not zero. A line stuck at 0 (bit 5) gives 0x20.
- R6: For N > 0, `busy` is high for exactly 2N+1 consecutive cycles, starting in the cycle after edge 0. In the next cycle `done` is high for one cycle with `busy` low, and the final `result` is valid in that cycle.
- R7: With N = 0, `done` pulses in the cycle after edge 0 with `result` = 0. `busy` never rises and there is no memory access.
- R8: When the window crosses the top of the address space, the address wraps to 0 and the write and read sequences continue from there.
- R9: `start` is ignored while `busy` or `done` is high. The running test keeps its addresses, its data and its result.
- R10: After `done`, `result` keeps its value until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a test |
| start_addr | input | ADDR_W | First address of the window |
| byte_count | input | CNT_W | Number of bytes to test |
| seed | input | 8 | Pattern seed (0 is replaced by 0x01) |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8 | Accumulated mismatch bits |
| mem_addr | output | ADDR_W | RAM address |
| mem_we | output | 1 | RAM write strobe |
| mem_re | output | 1 | RAM read request |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, one cycle after `mem_re` |

## Verification
The bench builds the engine with ADDR_W = 8 and CNT_W = 9. With these values a 256-byte RAM model covers the whole address space. This makes a window that crosses address 255 cheap to reach, and it lets a single run sweep all 256 locations. The RAM model can inject a wired-AND short between data lines 1 and 2, or a stuck-at-0 on line 5. The bench predicts the exact result for each fault from its own pattern generator.

// File: rtl/ramtest_pkg.sv
// Shared constants and types for the RAM test engine.
package ramtest_pkg;
    localparam int BYTE_W = 8;                 // data width of the tested RAM
    localparam logic [BYTE_W-1:0] LFSR_TAPS = 8'hB8; // x^8+x^6+x^5+x^4+1

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WRITE,
        PH_READ,
        PH_DRAIN,
        PH_FIN
    } phase_t;
endpackage

// File: rtl/ramtest_lfsr.sv
// Pattern generator: Fibonacci LFSR, shift left, feedback = XOR of tapped bits.
// Assumes load, rewind and step are never needed together except rewind+step,
// where rewind wins. A zero seed is replaced by 1 to avoid the lock-up state.
module ramtest_lfsr
    import ramtest_pkg::*;
#(
    parameter int WIDTH = BYTE_W,
    parameter logic [WIDTH-1:0] TAPS = LFSR_TAPS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             rewind,
    input  logic             step,
    input  logic [WIDTH-1:0] seed,
    output logic [WIDTH-1:0] value
);
    logic [WIDTH-1:0] seed_q;
    logic [WIDTH-1:0] seed_eff;
    logic             fb;

    // Substitute a legal seed and form the feedback bit.
    always_comb begin
        seed_eff = (seed == '0) ? WIDTH'(1) : seed;
        fb       = ^(value & TAPS);
    end

    // Hold the current pattern byte and the seed used for rewinding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value  <= '0;
            seed_q <= '0;
        end else if (load) begin
            value  <= seed_eff;
            seed_q <= seed_eff;
        end else if (rewind) begin
            value  <= seed_q;
        end else if (step) begin
            value  <= {value[WIDTH-2:0], fb};
        end
    end
endmodule

// File: rtl/ramtest_addr_seq.sv
// Address sequencer: walks the window one byte per step, wrapping modulo
// 2^ADDR_W, and counts the bytes left in the current pass.
// Assumes step is only given while at least one byte remains.
module ramtest_addr_seq #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              rewind,
    input  logic              step,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [CNT_W-1:0]  count_in,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  count_q;
    logic [CNT_W-1:0]  remain;

    // Flag the final byte of a pass.
    always_comb last = (remain == CNT_W'(1));

    // Track the address, the saved window and the bytes remaining.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr    <= '0;
            base_q  <= '0;
            count_q <= '0;
            remain  <= '0;
        end else if (load) begin
            addr    <= base_in;
            base_q  <= base_in;
            count_q <= count_in;
            remain  <= count_in;
        end else if (rewind) begin
            addr    <= base_q;
            remain  <= count_q;
        end else if (step) begin
            addr    <= addr + ADDR_W'(1);
            remain  <= remain - CNT_W'(1);
        end
    end
endmodule

// File: rtl/ramtest_ctrl.sv
// Pass controller: idle -> write pass -> read pass -> one drain cycle for the
// last read byte -> one done cycle. Starts are only taken while idle.
module ramtest_ctrl
    import ramtest_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cnt_zero,
    input  logic last,
    output logic busy,
    output logic done,
    output logic we,
    output logic re,
    output logic load,
    output logic rewind,
    output logic step
);
    phase_t phase, phase_nxt;

    // Decode strobes and the next phase from the current phase.
    always_comb begin
        phase_nxt = phase;
        load      = 1'b0;
        rewind    = 1'b0;
        step      = 1'b0;
        we        = 1'b0;
        re        = 1'b0;
        unique case (phase)
            PH_IDLE: if (start) begin
                load      = 1'b1;
                phase_nxt = cnt_zero ? PH_FIN : PH_WRITE;
            end
            PH_WRITE: begin
                we = 1'b1;
                if (last) begin
                    rewind    = 1'b1;
                    phase_nxt = PH_READ;
                end else begin
                    step = 1'b1;
                end
            end
            PH_READ: begin
                re = 1'b1;
                if (last) phase_nxt = PH_DRAIN;
                else      step      = 1'b1;
            end
            PH_DRAIN: phase_nxt = PH_FIN;
            PH_FIN:   phase_nxt = PH_IDLE;
            default:  phase_nxt = PH_IDLE;
        endcase
        busy = (phase == PH_WRITE) || (phase == PH_READ) || (phase == PH_DRAIN);
        done = (phase == PH_FIN);
    end

    // Advance the phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nxt;
    end
endmodule

// File: rtl/ramtest_cmp.sv
// Read-back comparator: remembers the expected byte of each read request and,
// one cycle later, ORs its XOR with the returned byte into the result.
// Assumes the RAM answers every read exactly one cycle after the request.
module ramtest_cmp
    import ramtest_pkg::*;
#(
    parameter int WIDTH = BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             capture,
    input  logic [WIDTH-1:0] expect_in,
    input  logic [WIDTH-1:0] rdata,
    output logic [WIDTH-1:0] acc
);
    logic [WIDTH-1:0] exp_q;
    logic             pend_q;

    // Pipeline the expected byte and accumulate mismatch bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q  <= '0;
            pend_q <= 1'b0;
            acc    <= '0;
        end else if (clear) begin
            pend_q <= 1'b0;
            acc    <= '0;
        end else begin
            pend_q <= capture;
            exp_q  <= expect_in;
            if (pend_q) acc <= acc | (rdata ^ exp_q);
        end
    end
endmodule

// File: rtl/ramtest_engine.sv
// Top of the RAM test engine: writes an LFSR byte stream over a window of a
// synchronous RAM, reads it back and reports the OR of all byte mismatches.
// Assumes a RAM with same-edge writes and one-cycle read latency.
module ramtest_engine
    import ramtest_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic [BYTE_W-1:0] seed,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] result,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata
);
    logic load, rewind, step, last, cnt_zero;
    logic [BYTE_W-1:0] pattern;

    // Detect an empty window at the moment of start.
    always_comb cnt_zero = (byte_count == '0);

    ramtest_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .cnt_zero(cnt_zero),
        .last(last), .busy(busy), .done(done), .we(mem_we), .re(mem_re),
        .load(load), .rewind(rewind), .step(step)
    );

    ramtest_addr_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .load(load), .rewind(rewind), .step(step),
        .base_in(start_addr), .count_in(byte_count), .addr(mem_addr), .last(last)
    );

    ramtest_lfsr #(.WIDTH(BYTE_W)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .load(load), .rewind(rewind), .step(step),
        .seed(seed), .value(pattern)
    );

    ramtest_cmp #(.WIDTH(BYTE_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .clear(load), .capture(mem_re),
        .expect_in(pattern), .rdata(mem_rdata), .acc(result)
    );

    // The write data is the live pattern byte.
    always_comb mem_wdata = pattern;
endmodule

// File: rtl/ramtest_engine_chk.sv
// Protocol checker for ramtest_engine, attached by bind.
module ramtest_engine_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [7:0]        result,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              mem_re
);
    // R6: done never overlaps busy
    a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R6: done is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3: never read and write together
    a_r3_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
    // R2: consecutive writes step the address by one, wrapping
    a_r2_write_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1)));
    // R3: consecutive reads step the address by one, wrapping
    a_r3_read_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1)));
    // R7: memory is touched only while busy
    a_r7_access_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> busy);
    // R10: result holds while idle
    a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && !$past(start)) |-> $stable(result));
endmodule

bind ramtest_engine ramtest_engine_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .result(result), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re)
);

// File: tb/ramtest_engine_tb_top.sv
module ramtest_engine_tb_top;
    localparam int AW = 8;
    localparam int CW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [CW-1:0] byte_count = '0;
    logic [7:0]    seed = '0;
    logic          busy, done, mem_we, mem_re;
    logic [7:0]    result, mem_wdata;
    logic [7:0]    mem_rdata = '0;
    logic [AW-1:0] mem_addr;

    int checks = 0;
    int fails  = 0;
    int fault_mode = 0;
    logic [7:0] ram [0:255];

    always #2 clk = ~clk;

    ramtest_engine #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .byte_count(byte_count), .seed(seed), .busy(busy), .done(done),
        .result(result), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] inject(input logic [7:0] d);
        logic [7:0] o = d;
        if (fault_mode == 1) begin
            o[1] = d[1] & d[2];
            o[2] = d[1] & d[2];
        end else if (fault_mode == 2) begin
            o[5] = 1'b0;
        end
        return o;
    endfunction

    // RAM model: same-edge write, one-cycle read latency.
    always_ff @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= inject(mem_wdata);
        if (mem_re) mem_rdata <= ram[mem_addr];
    end

    function automatic logic [7:0] lfsr_next(input logic [7:0] v);
        return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [7:0] sa, input int n, input logic [7:0] sd,
                       input int mode, input bit poke, input string tag);
        logic [7:0] p [$];
        logic [7:0] v;
        logic [7:0] exp_res;
        int last_c;
        fault_mode = mode;
        v = (sd == 8'h00) ? 8'h01 : sd;
        exp_res = 8'h00;
        for (int i = 0; i < n; i++) begin
            p.push_back(v);
            exp_res = exp_res | (inject(v) ^ v);
            v = lfsr_next(v);
        end
        @(negedge clk);
        start_addr = sa; byte_count = CW'(n); seed = sd; start = 1'b1;
        last_c = (n == 0) ? 1 : 2 * n + 2;
        for (int c = 1; c <= last_c + 4; c++) begin
            bit e_busy, e_done, e_we, e_re;
            logic [7:0] e_addr;
            @(negedge clk);
            start = 1'b0;
            e_busy = (n > 0) && (c <= 2 * n + 1);
            e_done = (c == last_c);
            e_we   = (c >= 1) && (c <= n);
            e_re   = (c > n) && (c <= 2 * n);
            e_addr = e_we ? sa + 8'(c - 1) : sa + 8'(c - n - 1);
            check(busy == e_busy, "R6", "busy", busy, e_busy);
            check(done == e_done, "R6", "done", done, e_done);
            check(mem_we == e_we, "R2", "mem_we", mem_we, e_we);
            check(mem_re == e_re, "R3", "mem_re", mem_re, e_re);
            if (e_we) begin
                check(mem_addr == e_addr, tag, "write addr", mem_addr, e_addr);
                check(mem_wdata == p[c-1], tag, "write data", mem_wdata, p[c-1]);
            end
            if (e_re)
                check(mem_addr == e_addr, tag, "read addr", mem_addr, e_addr);
            if (c == last_c)
                check(result == exp_res, tag, "result at done", result, exp_res);
            if (c > last_c)
                check(result == exp_res, "R10", "result held", result, exp_res);
            if (poke && c == 3) begin
                start = 1'b1; start_addr = ~sa; byte_count = CW'(5); seed = 8'h11;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1", "busy", busy, 0);
        check(done == 1'b0, "R1", "done", done, 0);
        check(result == 8'h00, "R1", "result", result, 0);
        check(mem_we == 1'b0 && mem_re == 1'b0, "R1", "mem strobes", {mem_we, mem_re}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run(8'h10, 20, 8'h5A, 0, 1'b0, "R4");   // healthy RAM, result 0
        run(8'hFA, 12, 8'h81, 0, 1'b0, "R8");   // window wraps past 255
        run(8'h00, 64, 8'h33, 1, 1'b0, "R5");   // bits 1 and 2 shorted
        check(result != 8'h00 && (result & 8'hF9) == 8'h00, "R5",
              "short only in bits 1,2", result, 8'h06);
        run(8'h40, 30, 8'hC7, 2, 1'b0, "R5");   // bit 5 stuck at 0
        check(result == 8'h20, "R5", "stuck bit 5", result, 8'h20);
        run(8'h20, 0, 8'h77, 0, 1'b0, "R7");    // empty window
        run(8'h30, 9, 8'h00, 0, 1'b0, "R2");    // zero seed replaced by 1
        run(8'h55, 16, 8'h9C, 2, 1'b1, "R9");   // start during busy ignored
        run(8'h80, 256, 8'hE1, 0, 1'b0, "R3");  // whole address space
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule